// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block sits next to an instruction prefetch queue. Each time the fetch stream jumps to a non-sequential address, the prefetch logic presents that target to the block. The block compares the target against all of its stored entries in the same cycle. On a hit it sends the instruction words stored for that target to the core, one word per request. At the same time it tells the prefetch queue to restart fetching from just past those stored words, so the core does not stall while program memory is reached again. On a miss it tells the prefetch queue to restart at the target itself. It then claims an entry and records the first instruction words that arrive from program memory.

There are fifteen general entries with least-recently-used replacement. One more entry is reserved for the interrupt-vector fetch and is reached only through a dedicated strobe. A lookup flagged as a data-constant read is ignored completely. A single invalidate input empties the whole cache.

Top module: `btc_top`

## Requirements
- R1: After reset all entries are empty. `hit_o`, `miss_o`, `pf_restart` and `str_valid` are low, and the first lookup of any address misses.
- R2: Every accepted lookup (`lk_valid` high, `lk_literal` low) produces exactly one of `hit_o` or `miss_o`, as a one-cycle pulse in the cycle after the request.
- R3: A general lookup (`lk_vector` low) hits exactly when a valid general entry carries a tag equal to `lk_addr`. All general entries are compared at once, and at most one of them can match.
- R4: On a hit, `str_valid` rises in the cycle after the lookup with word 0 of the entry on `str_data`. Each cycle with `rd_req` high while `str_valid` is high advances to the next word. After word 7 is taken, `str_valid` falls.
- R5: `pf_restart` pulses in the cycle after every accepted lookup. `pf_addr` then equals the target plus 32 (eight 4-byte words) on a hit, or the target itself on a miss.
- R6: A miss claims an entry, tags it with the target, and writes the next eight `fill_valid` words into it in order. The entry answers lookups only after the eighth word is written. Fill words that arrive while no fill is pending are ignored.
- R7: A general miss replaces the least recently used general entry. Both a general hit and a general allocation make that entry the most recently used. Before any use, the order from most to least recently used is entry 0 through entry 14.
- R8: With `lk_vector` high, a lookup compares and allocates only the reserved sixteenth entry and leaves the replacement order unchanged. A general lookup never hits or allocates that entry.
- R9: A lookup with `lk_literal` high causes no hit, miss, prefetch restart, allocation or stream interruption.
- R10: `inv` clears every entry in one cycle and stops any pending fill and any active stream. A lookup in the same cycle as `inv` misses.
- R11: A miss abandons any pending fill, leaving that entry empty, and stops the active stream. A hit replaces the active stream with the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Non-sequential fetch request |
| lk_addr | input | ADDR_W | Branch target byte address |
| lk_literal | input | 1 | Request is a data-constant read; ignore it |
| lk_vector | input | 1 | Request is the interrupt-vector fetch |
| inv | input | 1 | Invalidate all entries |
| fill_valid | input | 1 | Instruction word from program memory is present |
| fill_data | input | DATA_W | Instruction word from program memory |
| rd_req | input | 1 | Core takes the current stream word |
| hit_o | output | 1 | Lookup hit, one cycle after the request |
| miss_o | output | 1 | Lookup miss, one cycle after the request |
| pf_restart | output | 1 | Prefetch queue restart strobe |
| pf_addr | output | ADDR_W | Prefetch restart address |
| str_valid | output | 1 | A stored word is presented |
| str_data | output | DATA_W | Stored instruction word |

## Verification
A corrupted replacement rank stays invisible until a later general miss evicts the wrong entry. It surfaces only as an unexpected miss on a lookup of a target that should have survived, which can be many lookups later. For this reason the bench's reference model tracks the replacement order and compares every cycle. A valid bit set too early, or a wrong fill offset, shows up on `str_data` one cycle after the next hit on that target. A broken tag compare shows on `hit_o`/`miss_o` and `pf_addr` one cycle after the lookup.

// File: rtl/btc_pkg.sv
package btc_pkg;
  localparam int unsigned BYTES_PER_WORD = 4;

  // byte distance from a hit target to where prefetch resumes
  function automatic int unsigned skip_bytes(int unsigned words);
    return words * BYTES_PER_WORD;
  endfunction

  // recency rank after a touch: touched entry becomes 0, younger ones age by 1
  function automatic int unsigned next_rank(int unsigned cur, int unsigned touched_rank, bit self);
    if (self) return 0;
    if (cur < touched_rank) return cur + 1;
    return cur;
  endfunction
endpackage

// File: rtl/btc_match.sv
module btc_match #(
  parameter int N  = 16,
  parameter int AW = 32,
  parameter int IW = 4
) (
  input  logic [N-1:0]  cand,
  input  logic [AW-1:0] tags [N],
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  hit_vec
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = cand[g] && (tags[g] == addr);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) idx = IW'(i);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/btc_lru.sv
module btc_lru #(
  parameter int N  = 15,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim,
  output logic [N-1:0]  victim_oh
);
  logic [IW-1:0] rank [N];
  logic [IW-1:0] touched_rank;

  always_comb begin
    touched_rank = '0;
    victim       = '0;
    for (int i = 0; i < N; i++) begin
      if (IW'(i) == touch_idx) touched_rank = rank[i];
      if (victim_oh[i]) victim = IW'(i);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_rank
    assign victim_oh[g] = (rank[g] == IW'(N - 1));
    always_ff @(posedge clk) begin
      if (!rst_n)
        rank[g] <= IW'(g);
      else if (touch)
        rank[g] <= IW'(btc_pkg::next_rank(rank[g], touched_rank, IW'(g) == touch_idx));
    end
  end
endmodule

// File: rtl/btc_store.sv
module btc_store #(
  parameter int N_ENT  = 16,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFS_W  = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_ent,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_ent,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [N_ENT][WORDS];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en && wr_ent == IDX_W'(g)) mem[g][wr_ofs] <= wr_data;
    end
  end

  assign rd_data = mem[rd_ent][rd_ofs];
endmodule

// File: rtl/btc_top.sv
module btc_top #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int N_GEN  = 15,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_literal,
  input  logic              lk_vector,
  input  logic              inv,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              rd_req,
  output logic              hit_o,
  output logic              miss_o,
  output logic              pf_restart,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              str_valid,
  output logic [DATA_W-1:0] str_data
);
  localparam int N_ENT   = N_GEN + 1;
  localparam int IDX_W   = $clog2(N_ENT);
  localparam int OFS_W   = $clog2(WORDS);
  localparam int VEC_IDX = N_GEN;
  localparam logic [OFS_W-1:0]  LAST_OFS = OFS_W'(WORDS - 1);
  localparam logic [N_ENT-1:0]  VEC_BIT  = N_ENT'(1) << VEC_IDX;
  localparam logic [ADDR_W-1:0] SKIP     = ADDR_W'(btc_pkg::skip_bytes(WORDS));

  logic [N_ENT-1:0]  ent_valid;
  logic [ADDR_W-1:0] ent_tag [N_ENT];

  // named internal events
  logic              lk_take, look_hit, look_miss, lru_touch;
  logic              fill_on, fill_wr;
  logic [IDX_W-1:0]  look_idx, gen_victim, alloc_idx, touch_idx, fill_ent, str_ent;
  logic [OFS_W-1:0]  fill_ofs, str_ofs;
  logic [N_ENT-1:0]  cand, hit_vec;
  logic [N_GEN-1:0]  victim_oh;

  assign lk_take   = lk_valid && !lk_literal;
  assign cand      = ent_valid & {N_ENT{!inv}} & (lk_vector ? VEC_BIT : ~VEC_BIT);
  assign look_miss = lk_take && !look_hit;
  assign alloc_idx = lk_vector ? IDX_W'(VEC_IDX) : gen_victim;
  assign lru_touch = lk_take && !lk_vector;
  assign touch_idx = look_hit ? look_idx : gen_victim;
  assign fill_wr   = fill_on && fill_valid;

  btc_match #(.N(N_ENT), .AW(ADDR_W), .IW(IDX_W)) u_match (
    .cand(cand), .tags(ent_tag), .addr(lk_addr),
    .hit(look_hit), .idx(look_idx), .hit_vec(hit_vec)
  );

  btc_lru #(.N(N_GEN), .IW(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(lru_touch), .touch_idx(touch_idx),
    .victim(gen_victim), .victim_oh(victim_oh)
  );

  btc_store #(.N_ENT(N_ENT), .WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_store (
    .clk(clk), .wr_en(fill_wr), .wr_ent(fill_ent), .wr_ofs(fill_ofs), .wr_data(fill_data),
    .rd_ent(str_ent), .rd_ofs(str_ofs), .rd_data(str_data)
  );

  // lookup result and prefetch restart
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_o      <= 1'b0;
      miss_o     <= 1'b0;
      pf_restart <= 1'b0;
      pf_addr    <= '0;
    end else begin
      hit_o      <= lk_take && look_hit;
      miss_o     <= look_miss;
      pf_restart <= lk_take;
      if (lk_take) pf_addr <= lk_addr + (look_hit ? SKIP : '0);
    end
  end

  // tags: written on allocation only
  always_ff @(posedge clk) begin
    if (look_miss) ent_tag[alloc_idx] <= lk_addr;
  end

  // valid bits and fill sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      fill_on   <= 1'b0;
      fill_ent  <= '0;
      fill_ofs  <= '0;
    end else begin
      if (fill_wr) begin
        fill_ofs <= fill_ofs + 1'b1;
        if (fill_ofs == LAST_OFS) begin
          ent_valid[fill_ent] <= 1'b1;
          fill_on             <= 1'b0;
        end
      end
      if (inv) begin
        ent_valid <= '0;
        fill_on   <= 1'b0;
      end
      if (look_miss) begin
        ent_valid[alloc_idx] <= 1'b0;
        fill_on              <= 1'b1;
        fill_ent             <= alloc_idx;
        fill_ofs             <= '0;
      end
    end
  end

  // output stream
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      str_valid <= 1'b0;
      str_ent   <= '0;
      str_ofs   <= '0;
    end else begin
      if (str_valid && rd_req) begin
        if (str_ofs == LAST_OFS) str_valid <= 1'b0;
        else                     str_ofs   <= str_ofs + 1'b1;
      end
      if (inv) str_valid <= 1'b0;
      if (lk_take) begin
        str_valid <= look_hit;
        str_ent   <= look_idx;
        str_ofs   <= '0;
      end
    end
  end
endmodule

// File: rtl/btc_chk.sv
module btc_chk #(
  parameter int ADDR_W  = 32,
  parameter int N_ENT   = 16,
  parameter int N_GEN   = 15,
  parameter int IDX_W   = 4,
  parameter int WORDS   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_literal,
  input logic              lk_vector,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              inv,
  input logic              hit_o,
  input logic              miss_o,
  input logic              pf_restart,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              str_valid,
  input logic [N_ENT-1:0]  hit_vec,
  input logic [N_GEN-1:0]  victim_oh,
  input logic              look_miss,
  input logic [IDX_W-1:0]  alloc_idx,
  input logic              fill_on
);
  localparam logic [ADDR_W-1:0] SKIP = ADDR_W'(btc_pkg::skip_bytes(WORDS));

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !(hit_o && miss_o)); // R2
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && !lk_literal) |=> (hit_o || miss_o)); // R2
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec)); // R3
  AST_STREAM_START: assert property (@(posedge clk) disable iff (!rst_n) hit_o |-> str_valid); // R4
  AST_PF_SKIP: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && !lk_literal && !inv && $countones(hit_vec) == 1) |=> (pf_addr == $past(lk_addr) + SKIP)); // R5
  AST_MISS_FILLS: assert property (@(posedge clk) disable iff (!rst_n) look_miss |=> fill_on); // R6
  AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n) $countones(victim_oh) == 1); // R7
  AST_VEC_RESERVED: assert property (@(posedge clk) disable iff (!rst_n) (look_miss && !lk_vector) |-> (alloc_idx != IDX_W'(N_GEN))); // R8
  AST_LITERAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && lk_literal) |=> !pf_restart); // R9
  AST_INV_MISS: assert property (@(posedge clk) disable iff (!rst_n) inv |=> !hit_o); // R10
endmodule

bind btc_top btc_chk #(
  .ADDR_W(ADDR_W), .N_ENT(N_ENT), .N_GEN(N_GEN), .IDX_W(IDX_W), .WORDS(WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_literal(lk_literal),
  .lk_vector(lk_vector), .lk_addr(lk_addr), .inv(inv), .hit_o(hit_o),
  .miss_o(miss_o), .pf_restart(pf_restart), .pf_addr(pf_addr),
  .str_valid(str_valid), .hit_vec(hit_vec), .victim_oh(victim_oh),
  .look_miss(look_miss), .alloc_idx(alloc_idx), .fill_on(fill_on)
);

// File: tb/sim_btc_top.sv
`timescale 1ns/1ps
module sim_btc_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_literal = 0, lk_vector = 0, inv = 0, fill_valid = 0, rd_req = 0;
  logic [31:0] lk_addr = '0, fill_data = '0;
  logic hit_o, miss_o, pf_restart, str_valid;
  logic [31:0] pf_addr, str_data;

  always #4 clk = ~clk;

  btc_top u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_literal(lk_literal), .lk_vector(lk_vector), .inv(inv),
    .fill_valid(fill_valid), .fill_data(fill_data), .rd_req(rd_req),
    .hit_o(hit_o), .miss_o(miss_o), .pf_restart(pf_restart), .pf_addr(pf_addr),
    .str_valid(str_valid), .str_data(str_data)
  );

  int total = 0, bad = 0;
  string phase = "R1";
  bit done = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] %s actual=%h expected=%h", req, phase, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [31:0] a, int i);
    return (a << 4) ^ (32'(i) * 32'h01010101) ^ 32'h5A000000;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_tag [16];
  bit          m_val [16];
  logic [31:0] m_mem [16][8];
  int          lru_q [$];
  bit f_on, s_on, e_hit, e_miss, e_pf;
  int f_ent, f_cnt, s_ent, s_idx;
  logic [31:0] e_pfa;

  always @(posedge clk) begin
    if (!rst_n) begin
      lru_q = {};
      for (int i = 0; i < 15; i++) lru_q.push_back(i);
      for (int i = 0; i < 16; i++) m_val[i] = 0;
      f_on = 0; s_on = 0; e_hit = 0; e_miss = 0; e_pf = 0; e_pfa = '0;
    end else begin
      bit lk, h;
      int hi, vic, k;
      lk = lk_valid && !lk_literal;
      hi = -1;
      for (int i = 0; i < 16; i++)
        if (m_val[i] && !inv && m_tag[i] == lk_addr && ((i == 15) == lk_vector)) hi = i;
      h = lk && (hi >= 0);
      vic = lk_vector ? 15 : lru_q[$];
      if (s_on && rd_req) begin
        if (s_idx == 7) s_on = 0; else s_idx++;
      end
      if (inv) s_on = 0;
      if (lk) begin s_on = h; s_ent = hi; s_idx = 0; end
      if (f_on && fill_valid) begin
        m_mem[f_ent][f_cnt] = fill_data;
        f_cnt++;
        if (f_cnt == 8) begin m_val[f_ent] = 1; f_on = 0; end
      end
      if (inv) begin
        for (int i = 0; i < 16; i++) m_val[i] = 0;
        f_on = 0;
      end
      if (lk && !h) begin
        m_tag[vic] = lk_addr; m_val[vic] = 0; f_on = 1; f_ent = vic; f_cnt = 0;
      end
      if (lk && !lk_vector) begin
        k = h ? hi : vic;
        for (int i = 0; i < lru_q.size(); i++)
          if (lru_q[i] == k) begin lru_q.delete(i); break; end
        lru_q.push_front(k);
      end
      e_hit = h; e_miss = lk && !h; e_pf = lk;
      if (lk) e_pfa = lk_addr + (h ? 32'd32 : 32'd0);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(hit_o == e_hit, "R3", "hit_o", 32'(hit_o), 32'(e_hit));
      chk(miss_o == e_miss, "R2", "miss_o", 32'(miss_o), 32'(e_miss));
      chk(pf_restart == e_pf, "R5", "pf_restart", 32'(pf_restart), 32'(e_pf));
      if (e_pf) chk(pf_addr == e_pfa, "R5", "pf_addr", pf_addr, e_pfa);
      chk(str_valid == s_on, "R4", "str_valid", 32'(str_valid), 32'(s_on));
      if (s_on) chk(str_data == m_mem[s_ent][s_idx], "R4", "str_data", str_data, m_mem[s_ent][s_idx]);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic look(logic [31:0] a, bit vec = 0, bit lit = 0);
    @(negedge clk);
    lk_valid = 1; lk_addr = a; lk_vector = vec; lk_literal = lit;
    @(negedge clk);
    lk_valid = 0; lk_vector = 0; lk_literal = 0;
  endtask

  task automatic fill(logic [31:0] a, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fill_valid = 1; fill_data = mk(a, i);
    end
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic load(logic [31:0] a, bit vec = 0);
    look(a, vec);
    fill(a, 8);
  endtask

  localparam logic [31:0] A0 = 32'h1000, C0 = 32'h3000, V0 = 32'h18, D0 = 32'h4000, E0 = 32'h4400;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R1";
    chk(!hit_o && !miss_o && !pf_restart && !str_valid, "R1", "idle outputs",
        {28'd0, hit_o, miss_o, pf_restart, str_valid}, 32'd0);
    look(A0);
    chk(miss_o == 1, "R1", "first lookup miss", 32'(miss_o), 32'd1);

    phase = "R6";
    fill(A0, 7);
    look(A0);
    chk(miss_o == 1, "R6", "partial entry not valid", 32'(miss_o), 32'd1);
    fill(A0, 8);
    look(A0);
    chk(hit_o == 1, "R6", "filled entry hits", 32'(hit_o), 32'd1);
    chk(str_data == mk(A0, 0), "R4", "first word", str_data, mk(A0, 0));
    chk(pf_addr == A0 + 32, "R5", "restart past words", pf_addr, A0 + 32);

    phase = "R4";
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rd_req = 1;
      @(negedge clk); rd_req = 0;
    end
    chk(str_valid == 0, "R4", "stream ends after 8", 32'(str_valid), 32'd0);

    phase = "R6";
    @(negedge clk); fill_valid = 1; fill_data = 32'hDEAD0000;
    repeat (3) @(negedge clk);
    fill_valid = 0;
    look(A0);
    chk(str_data == mk(A0, 0), "R6", "idle fill ignored", str_data, mk(A0, 0));

    phase = "R7";
    for (int i = 1; i <= 14; i++) load(32'h2000 + 32'(i) * 64);
    look(A0);
    chk(hit_o == 1, "R7", "A0 still present", 32'(hit_o), 32'd1);
    load(C0);
    look(32'h2040);
    chk(miss_o == 1, "R7", "LRU entry evicted", 32'(miss_o), 32'd1);
    look(A0);
    chk(hit_o == 1, "R7", "MRU entry kept", 32'(hit_o), 32'd1);

    phase = "R8";
    load(V0, 1);
    look(V0, 1);
    chk(hit_o == 1, "R8", "vector entry hit", 32'(hit_o), 32'd1);
    chk(str_data == mk(V0, 0), "R8", "vector word", str_data, mk(V0, 0));
    look(V0, 0);
    chk(miss_o == 1, "R8", "general lookup skips vector entry", 32'(miss_o), 32'd1);
    look(V0, 1);
    chk(hit_o == 1, "R8", "vector entry untouched", 32'(hit_o), 32'd1);

    phase = "R9";
    look(A0);
    look(C0, 0, 1);
    chk(!pf_restart && !hit_o && !miss_o, "R9", "literal quiet",
        {29'd0, pf_restart, hit_o, miss_o}, 32'd0);
    chk(str_valid == 1 && str_data == mk(A0, 0), "R9", "stream intact", str_data, mk(A0, 0));

    phase = "R10";
    @(negedge clk); inv = 1;
    @(negedge clk); inv = 0;
    chk(str_valid == 0, "R10", "stream stopped", 32'(str_valid), 32'd0);
    look(A0);
    chk(miss_o == 1, "R10", "miss after invalidate", 32'(miss_o), 32'd1);
    fill(A0, 8);
    @(negedge clk); lk_valid = 1; lk_addr = A0; inv = 1;
    @(negedge clk); lk_valid = 0; inv = 0;
    chk(miss_o == 1, "R10", "same-cycle invalidate misses", 32'(miss_o), 32'd1);

    phase = "R11";
    look(D0);
    fill(D0, 4);
    load(E0);
    look(E0);
    chk(hit_o == 1, "R11", "new fill completes", 32'(hit_o), 32'd1);
    look(D0);
    chk(miss_o == 1, "R11", "abandoned fill stays empty", 32'(miss_o), 32'd1);

    phase = "R3";
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      lk_valid   = ($urandom % 100) < 25;
      lk_literal = ($urandom % 100) < 10;
      lk_vector  = ($urandom % 100) < 10;
      lk_addr    = 32'h8000 + 32'($urandom % 20) * 4;
      inv        = ($urandom % 300) == 0;
      fill_valid = ($urandom % 100) < 60;
      fill_data  = $urandom;
      rd_req     = ($urandom % 100) < 50;
    end
    @(negedge clk);
    lk_valid = 0; inv = 0; fill_valid = 0; rd_req = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog [%s] actual=running expected=finished", phase);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule